// File: doc/BRIEF.md
# SPI Word Master

This block is the serial engine of an SPI master. It sends and receives one word per transfer. A transfer is 8 or 16 bits long. It drives the serial clock, the outgoing data line and an optional active-low select line, and it samples the incoming data line. Clock polarity and clock phase are set separately, which gives the four usual SPI clock formats. Either end of the word can go first on the wire.

Software sets up the transfer through a set of configuration inputs that are loaded by a write strobe. The block takes these values only while it is idle. A write that arrives during a transfer is dropped, so a transfer in progress cannot be disturbed.

The outgoing word arrives on a valid/ready handshake. The block raises `tx_ready` only while idle, and a word is taken on any cycle where `tx_valid` and `tx_ready` are both high. The sender must hold `tx_valid` and `tx_data` until that cycle. The received word comes out as a one-cycle `rx_valid` pulse with `rx_data`. There is no back-pressure on the receive side: the consumer must take the word in that cycle. `rx_data` then holds its value until the next transfer completes.

Top module: `spi_word_master`

## Requirements
- R1: `sck` idles at the level of the stored polarity bit. With phase 0, the block samples `miso` on odd-numbered clock edges and changes `mosi` on even-numbered edges. With phase 1, it changes `mosi` on odd edges and samples on even edges. Edges are counted from 1 within a transfer.
- R2: With a stored half-period value H, consecutive `sck` edges are H system clocks apart, so one `sck` period is 2H clocks. A written value of 0 is stored as 1.
- R3: With the bit-order input at 0, word bit N-1 goes out first and the first received bit lands in bit N-1. With it at 1, bit 0 goes out first and the first received bit lands in bit 0.
- R4: With the word-size input at 0, a transfer is 8 bits: it sends `tx_data[7:0]` and returns the received byte in `rx_data[7:0]`, with `rx_data[15:8]` = 0. With it at 1, a transfer is 16 bits.
- R5: `ss_n` goes low only when both the fault-enable bit and the select-output-enable bit are stored as 1. In every other case it stays high.
- R6: The transfer window opens on the clock edge that accepts the word, and automatic `ss_n` falls at that same edge. The first `sck` edge comes H clocks later. The window closes at the last `sck` edge for phase 0, or H clocks after the last edge for phase 1. `ss_n` rises and `rx_valid` rises at that closing edge.
- R7: `tx_ready` is high exactly while the block is idle. A word is accepted when `tx_valid` and `tx_ready` are both high, and `tx_ready` is low from the next cycle until the transfer completes.
- R8: `rx_valid` is high for exactly one cycle per transfer. `rx_data` carries the received word during that cycle and holds it afterwards. `tx_ready` is already high in the `rx_valid` cycle.
- R9: A configuration write (`cfg_we`) while a transfer is running has no effect. Neither that transfer nor later ones change, and `sck` returns to the old idle level.
- R10: With phase 0, the first data bit is on `mosi` from the cycle right after acceptance, which is before the first `sck` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe; honoured only while idle |
| cfg_cpol | input | 1 | Clock polarity (idle level of `sck`) |
| cfg_cpha | input | 1 | Clock phase |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_wide | input | 1 | 0 = 8-bit word, 1 = 16-bit word |
| cfg_fault_en | input | 1 | Fault-enable bit, one of the two gates of automatic select |
| cfg_ss_oe | input | 1 | Select-output enable, the other gate of automatic select |
| cfg_half | input | HALF_W | Half-period of `sck` in system clocks (0 treated as 1) |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Block idle and able to accept a word |
| tx_data | input | WORD_W | Word to transmit |
| rx_valid | output | 1 | One-cycle pulse: received word available |
| rx_data | output | WORD_W | Received word |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
Properties are checked on every cycle:
- `sck` sits at the idle level whenever the block is idle.
- `ss_n` never falls unless both enables are stored.
- `ss_n` is never low outside a transfer, and `sck` has not moved at the moment `ss_n` falls.
- The handshake drops `tx_ready` after acceptance.
- `rx_valid` is a single-cycle pulse.
- The stored mode is frozen while a transfer is busy.

Some behaviour can only be shown by the bench's scenarios, using a slave model that follows the clock edges:
- which edges carry sampling and which carry changes, in all four formats;
- the bit order and word size seen on the wire and in `rx_data`;
- the exact H-clock spacing of the edges and of the select window;
- the effect of a dropped configuration write on later transfers.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
    logic wide;
    logic fault_en;
    logic ss_oe;
  } spi_mode_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } spi_state_e;

endpackage

// File: rtl/spi_cfg_reg.sv
module spi_cfg_reg
  import spi_xfer_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              idle,
  input  spi_mode_t         mode_in,
  input  logic [HALF_W-1:0] half_in,
  output spi_mode_t         mode_q,
  output logic [HALF_W-1:0] half_q
);

  localparam logic [HALF_W-1:0] HALF_MIN = HALF_W'(1);

  // writes land only between transfers; a busy-time write is dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      half_q <= HALF_MIN;
    end else if (we && idle) begin
      mode_q <= mode_in;
      half_q <= (half_in == '0) ? HALF_MIN : half_in;
    end
  end

endmodule

// File: rtl/spi_edge_timer.sv
module spi_edge_timer #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);

  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] reload;

  assign reload = half - HALF_W'(1);
  assign tick   = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= reload;
    end else if (run) begin
      cnt_q <= (cnt_q == '0) ? reload : cnt_q - HALF_W'(1);
    end
  end

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              lsb_first,
  input  logic              wide,
  input  logic              shift_out,
  input  logic              sample,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word
);

  logic [WORD_W-1:0] tx_sr;
  logic [WORD_W-1:0] rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
    end else if (load) begin
      tx_sr <= tx_word;
    end else if (shift_out) begin
      tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr <= '0;
    end else if (load) begin
      rx_sr <= '0;
    end else if (sample) begin
      rx_sr <= lsb_first ? {miso, rx_sr[WORD_W-1:1]} : {rx_sr[WORD_W-2:0], miso};
    end
  end

  // narrow words sit at the top of the register when they enter from the top
  always_comb begin
    if (lsb_first) mosi = tx_sr[0];
    else if (wide) mosi = tx_sr[WORD_W-1];
    else           mosi = tx_sr[NARROW_W-1];

    if (wide)           rx_word = rx_sr;
    else if (lsb_first) rx_word = WORD_W'(rx_sr[WORD_W-1 -: NARROW_W]);
    else                rx_word = WORD_W'(rx_sr[NARROW_W-1:0]);
  end

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_xfer_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8,
  parameter int HALF_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              cfg_wide,
  input  logic              cfg_fault_en,
  input  logic              cfg_ss_oe,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n
);

  localparam int EDGE_W = $clog2(2 * WORD_W + 2);
  localparam logic [EDGE_W-1:0] EDGES_WIDE   = EDGE_W'(2 * WORD_W);
  localparam logic [EDGE_W-1:0] EDGES_NARROW = EDGE_W'(2 * NARROW_W);

  spi_state_e        state_q;
  spi_mode_t         mode_in, mode_q;
  logic [HALF_W-1:0] half_q;
  logic [EDGE_W-1:0] edge_cnt_q, next_edge, last_edge, end_edge;
  logic              phase_q;
  logic              idle, accept, running, tick;
  logic              clk_edge, odd_edge, sample, shift_out, finish;
  logic [WORD_W-1:0] rx_word;

  assign mode_in = '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first,
                     wide: cfg_wide, fault_en: cfg_fault_en, ss_oe: cfg_ss_oe};

  assign idle     = (state_q == ST_IDLE);
  assign running  = (state_q == ST_RUN);
  assign accept   = idle && tx_valid;
  assign tx_ready = idle;

  spi_cfg_reg #(.HALF_W(HALF_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idle(idle),
    .mode_in(mode_in), .half_in(cfg_half), .mode_q(mode_q), .half_q(half_q)
  );

  spi_edge_timer #(.HALF_W(HALF_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(running),
    .half(half_q), .tick(tick)
  );

  // edge bookkeeping: tick k is sck edge k; phase 1 adds one trailing tick
  assign next_edge = edge_cnt_q + EDGE_W'(1);
  assign last_edge = mode_q.wide ? EDGES_WIDE : EDGES_NARROW;
  assign end_edge  = last_edge + EDGE_W'(mode_q.cpha);
  assign clk_edge  = tick && (next_edge <= last_edge);
  assign odd_edge  = next_edge[0];
  assign sample    = clk_edge && (mode_q.cpha ? !odd_edge : odd_edge);
  assign shift_out = clk_edge && (mode_q.cpha ? (odd_edge && next_edge != EDGE_W'(1))
                                              : !odd_edge);
  assign finish    = tick && (next_edge == end_edge);

  spi_shift_unit #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .tx_word(tx_data),
    .lsb_first(mode_q.lsb_first), .wide(mode_q.wide),
    .shift_out(shift_out), .sample(sample), .miso(miso),
    .mosi(mosi), .rx_word(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      edge_cnt_q <= '0;
      phase_q    <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (accept) begin
        state_q    <= ST_RUN;
        edge_cnt_q <= '0;
        phase_q    <= 1'b0;
      end else if (running && tick) begin
        edge_cnt_q <= next_edge;
        if (clk_edge) phase_q <= !phase_q;
        if (finish) begin
          state_q  <= ST_IDLE;
          rx_valid <= 1'b1;
          rx_data  <= rx_word;
        end
      end
    end
  end

  // polarity acts as an inverter in series with the internal clock phase
  assign sck  = mode_q.cpol ^ phase_q;
  assign ss_n = !(running && mode_q.fault_en && mode_q.ss_oe);

endmodule

// File: rtl/spi_word_master_chk.sv
module spi_word_master_chk
  import spi_xfer_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      tx_valid,
  input logic      tx_ready,
  input logic      rx_valid,
  input logic      sck,
  input logic      ss_n,
  input spi_mode_t mode
);

  // R1: idle clock level follows the stored polarity
  a_r1_sck_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (sck == mode.cpol));

  // R5: select needs both enables
  a_r5_ss_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode.fault_en && mode.ss_oe) |-> ss_n);

  // R6: select only inside a transfer window
  a_r6_ss_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n |-> !tx_ready);

  // R6: no clock edge at the moment select falls
  a_r6_ss_leads_sck: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> (sck == mode.cpol));

  // R7: acceptance makes the block busy
  a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R8: done is a single-cycle pulse, issued when the block is idle again
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> tx_ready);

  // R9: stored mode frozen while busy
  a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !$past(tx_ready)) |-> $stable(mode));

endmodule

bind spi_word_master spi_word_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .sck(sck), .ss_n(ss_n), .mode(mode_q)
);

// File: tb/spi_word_master_tb.sv
`timescale 1ns/1ps
module spi_word_master_tb;

  localparam int WORD_W   = 16;
  localparam int NARROW_W = 8;
  localparam int HALF_W   = 8;
  localparam int CYC      = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              cfg_we = 0, cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0;
  logic              cfg_wide = 0, cfg_fault_en = 0, cfg_ss_oe = 0;
  logic [HALF_W-1:0] cfg_half = 1;
  logic              tx_valid = 0;
  logic [WORD_W-1:0] tx_data = 0;
  logic              miso = 0;
  logic              tx_ready, rx_valid, sck, mosi, ss_n;
  logic [WORD_W-1:0] rx_data;

  spi_word_master #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .HALF_W(HALF_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_wide(cfg_wide), .cfg_fault_en(cfg_fault_en),
    .cfg_ss_oe(cfg_ss_oe), .cfg_half(cfg_half), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data), .sck(sck), .mosi(mosi),
    .miso(miso), .ss_n(ss_n)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [15:0] rx;
    logic [15:0] tx;
    int          h;
    bit          cpha;
    bit          autoss;
  } item_t;

  item_t sb_q[$];
  event  done_ev;

  // slave model state
  bit          in_xfer = 0;
  bit          cur_cpha, cur_lsb;
  int          cur_n, edge_n, cap_n, s_idx;
  logic [15:0] cap, s_word;
  bit          ss_low_seen;
  time         t_acc, t_e1, t_e2, t_last, t_ssfall, t_ssrise, t_done;

  function automatic logic s_bit(input int k);
    if (k >= cur_n) return 1'b0;
    return cur_lsb ? s_word[k] : s_word[cur_n-1-k];
  endfunction

  always @(sck) begin
    if (in_xfer) begin
      edge_n++;
      if (edge_n == 1) t_e1 = $time;
      if (edge_n == 2) t_e2 = $time;
      t_last = $time;
      if (((edge_n % 2) == 1) != cur_cpha) begin
        if (cur_lsb) cap[cap_n] = mosi;
        else         cap = {cap[14:0], mosi};
        cap_n++;
      end else if (cur_cpha) begin
        miso = s_bit(s_idx);
        s_idx++;
      end else begin
        s_idx++;
        miso = s_bit(s_idx);
      end
    end
  end

  always @(negedge ss_n) if (in_xfer) begin ss_low_seen = 1; t_ssfall = $time; end
  always @(posedge ss_n) t_ssrise = $time;
  always @(posedge rx_valid) t_done = $time;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rx_valid) begin : mon
      item_t it;
      if (sb_q.size() == 0) begin
        chk(0, "R8", "unexpected completion", 1, 0);
      end else begin
        it = sb_q.pop_front();
        chk(rx_data == it.rx, "R1 R3 R4 R8", "received word", rx_data, it.rx);
        chk(cap == it.tx, "R1 R3 R4", "word seen on mosi", cap, it.tx);
        chk((t_e1 - t_acc) / CYC == it.h, "R6", "accept to first edge", (t_e1 - t_acc) / CYC, it.h);
        chk((t_e2 - t_e1) / CYC == it.h, "R2", "edge spacing", (t_e2 - t_e1) / CYC, it.h);
        chk((t_done - t_last) / CYC == (it.cpha ? it.h : 0), "R6", "last edge to done",
            (t_done - t_last) / CYC, it.cpha ? it.h : 0);
        if (it.autoss) begin
          chk(ss_low_seen && t_ssfall == t_acc, "R5 R6", "select fall time", t_ssfall, t_acc);
          chk(t_ssrise == t_done, "R6", "select rise time", t_ssrise, t_done);
        end else begin
          chk(!ss_low_seen, "R5", "select stayed high", ss_low_seen, 0);
        end
      end
      -> done_ev;
    end
  end

  bit rv_prev = 0;
  always @(negedge clk) begin
    if (rv_prev) chk(!rx_valid, "R8", "done pulse width", rx_valid, 0);
    rv_prev = rx_valid;
  end

  task automatic set_cfg(input bit pol, input bit pha, input bit lsb, input bit wide,
                         input bit fe, input bit oe, input int half);
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb; cfg_wide = wide;
    cfg_fault_en = fe; cfg_ss_oe = oe; cfg_half = HALF_W'(half); cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic xfer(input logic [15:0] w, input logic [15:0] sw, input bit pha,
                      input bit lsb, input bit wide, input int h, input bit autoss);
    item_t       it;
    int          n = wide ? 16 : 8;
    logic [15:0] m = wide ? 16'hFFFF : 16'h00FF;
    it.rx = sw & m; it.tx = w & m; it.h = h; it.cpha = pha; it.autoss = autoss;
    sb_q.push_back(it);
    @(negedge clk);
    cur_cpha = pha; cur_lsb = lsb; cur_n = n; s_word = sw;
    edge_n = 0; cap_n = 0; cap = 0; s_idx = 0; ss_low_seen = 0;
    miso = pha ? 1'b0 : s_bit(0);
    in_xfer = 1;
    tx_valid = 1; tx_data = w;
    @(posedge clk);
    t_acc = $time;
    @(negedge clk);
    tx_valid = 0;
    chk(tx_ready == 0, "R7", "busy after accept", tx_ready, 0);
    if (!pha) chk(mosi == (lsb ? w[0] : w[n-1]), "R10", "first bit before first edge",
                  mosi, lsb ? w[0] : w[n-1]);
    @(done_ev);
    in_xfer = 0;
    chk(tx_ready == 1, "R7 R8", "idle at completion", tx_ready, 1);
  endtask

  initial begin
    #(CYC * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sck == 0, "R1", "reset sck", sck, 0);
    chk(ss_n == 1, "R5", "reset select", ss_n, 1);
    chk(tx_ready == 1, "R7", "reset ready", tx_ready, 1);
    chk(rx_valid == 0, "R8", "reset done", rx_valid, 0);
    rst_n = 1;

    // all four clock formats, 8-bit MSB-first with automatic select
    set_cfg(0, 0, 0, 0, 1, 1, 2);
    xfer(16'h12A5, 16'h003C, 0, 0, 0, 2, 1);
    set_cfg(1, 0, 0, 0, 1, 1, 2);
    @(negedge clk); chk(sck == 1, "R1", "idle level polarity 1", sck, 1);
    xfer(16'h005A, 16'h00C3, 0, 0, 0, 2, 1);
    set_cfg(0, 1, 0, 0, 1, 1, 2);
    xfer(16'h0081, 16'h007E, 1, 0, 0, 2, 1);
    set_cfg(1, 1, 0, 0, 1, 1, 2);
    xfer(16'h00F0, 16'h0011, 1, 0, 0, 2, 1);

    // 16-bit, LSB-first, half period 3
    set_cfg(0, 1, 1, 1, 1, 1, 3);
    xfer(16'hC3A1, 16'h1E5B, 1, 1, 1, 3, 1);
    // 8-bit LSB-first, fastest clock
    set_cfg(1, 0, 1, 0, 1, 1, 1);
    xfer(16'hFF6D, 16'h0029, 0, 1, 0, 1, 1);
    // half period written as 0 behaves as 1, 16-bit MSB-first
    set_cfg(1, 0, 0, 1, 1, 1, 0);
    xfer(16'h8001, 16'h7FFE, 0, 0, 1, 1, 1);

    // select held high unless both enables are set
    set_cfg(0, 0, 0, 0, 1, 0, 2);
    xfer(16'h0033, 16'h00CC, 0, 0, 0, 2, 0);
    set_cfg(0, 1, 0, 0, 0, 1, 2);
    xfer(16'h0096, 16'h0069, 1, 0, 0, 2, 0);

    // configuration write during a transfer is dropped
    set_cfg(0, 0, 0, 0, 1, 1, 2);
    fork
      xfer(16'h004B, 16'h00B4, 0, 0, 0, 2, 1);
      begin
        repeat (8) @(negedge clk);
        set_cfg(1, 1, 1, 1, 0, 0, 5);
      end
    join
    @(negedge clk);
    chk(sck == 0, "R9", "idle level unchanged by busy write", sck, 0);
    xfer(16'h00D2, 16'h002D, 0, 0, 0, 2, 1);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule